// File: doc/BRIEF.md
# Flow Record Batcher with Timeout

This block gathers fixed-size flow records from a streaming source and groups them into batches for an export path. Records arrive as beats on an AXI4-Stream slave port. Every accepted beat is written into an internal FIFO and is also folded into a running 16-bit ones'-complement sum, so the partial checksum is ready when the batch ends, with no second pass over the data.

A batch closes in one of two ways. It closes when the record count reaches its maximum. It also closes when a cycle-count timeout, started by the first complete record of the batch, runs out. An empty batch never closes. When a batch closes, the block raises a ready flag and presents the record count and the checksum. It then refuses further input until the controller acknowledges.

The controller normally acknowledges at the moment it begins draining the FIFO. The FIFO read port is separate from the handshake, so records for the next batch can stream in while the previous batch is still being read out. Header generation and frame transmission live elsewhere.

Top module: `flow_batcher`

## Requirements
- R1: After reset, s_tready is 1, b_ready is 0, f_empty is 1, b_count is 0 and b_csum is 0.
- R2: A record is RECORD_BYTES (48) bytes, carried as RECORD_BYTES/(DATA_W/8) beats (6 at DATA_W=64). A record counts toward the batch only once its last beat is accepted.
- R3: When the FIFO holds FIFO_RECS*beats-per-record beats, s_tready is 0 and no beat is stored. Reading one beat makes s_tready 1 again.
- R4: When the record count reaches MAX_RECS (30), b_ready is 1 after the same clock edge that accepted the last beat, with b_count equal to MAX_RECS. With MAX_RECS-1 records held, b_ready stays 0.
- R5: With 1 to MAX_RECS-1 whole records held and no record partly received, b_ready rises on the (TIMEOUT_CYC+1)-th rising edge after the edge that completed the first record of the batch, and not before.
- R6: With no record held, the batch never closes, however long the wait.
- R7: While b_ready is 1 and b_ack is 0: s_tready is 0, and b_count, b_csum and the FIFO contents do not change.
- R8: b_ack while b_ready is 1 drops b_ready after that edge, clears the count, timer and checksum, and opens a new batch. b_ack while b_ready is 0 has no effect.
- R9: b_csum is the ones'-complement sum (end-around carry) of every 16-bit word of the accepted beats of the batch, with word k of a beat being s_tdata[16k+15:16k]. It is 0 for a batch before any beat.
- R10: f_rd_data shows the oldest stored beat whenever f_empty is 0. f_rd_en pops it. f_rd_en while f_empty is 1 has no effect.
- R11: A timeout that expires while a record is partly received does not close the batch. The batch closes on the edge that accepts that record's last beat, and that record is counted.
- R12: Beats leave the FIFO in arrival order, across batch boundaries. A new batch can be received while beats of an acknowledged batch are still unread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| s_tdata | input | DATA_W | Record data beat |
| s_tvalid | input | 1 | Beat valid |
| s_tready | output | 1 | Beat accepted when high together with s_tvalid |
| b_ready | output | 1 | Batch closed; count and checksum valid |
| b_count | output | $clog2(MAX_RECS+1) | Records in the closed batch |
| b_csum | output | 16 | Partial ones'-complement checksum of the batch |
| b_ack | input | 1 | Controller acknowledge, one cycle |
| f_rd_en | input | 1 | Pop the oldest FIFO beat |
| f_rd_data | output | DATA_W | Oldest FIFO beat (show-ahead) |
| f_empty | output | 1 | FIFO holds no beat |

## Verification
The closing rule is tried with several input patterns, each meant to fail a different kind of error. A full batch of 30 back-to-back records separates count closing from timer closing. A single record, timed edge by edge, pins down where the timeout begins and ends. A record left half-sent past the timeout shows that only whole records close a batch. A long idle wait with nothing held shows that an empty batch never closes, and stray acknowledges sent while collecting show that they do not clear the batch. A run that fills the FIFO across two acknowledged batches, followed by a full drain and reads while empty, checks back-pressure, ordering across batches and pointer safety.

// File: rtl/flow_batch_pkg.sv
package flow_batch_pkg;

    typedef enum logic {
        ST_COLLECT = 1'b0,
        ST_READY   = 1'b1
    } batch_state_e;

endpackage

// File: rtl/fb_fifo.sv
module fb_fifo #(
    parameter int W     = 64,
    parameter int DEPTH = 360
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] level;
    } ptr_t;

    ptr_t q, d;
    logic [W-1:0] mem [DEPTH];
    logic do_wr, do_rd;

    assign full    = (q.level == CW'(DEPTH));
    assign empty   = (q.level == '0);
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[q.rp];

    always_comb begin
        d = q;
        if (do_wr) begin
            d.wp = (q.wp == AW'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
        end
        if (do_rd) begin
            d.rp = (q.rp == AW'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
        end
        case ({do_wr, do_rd})
            2'b10:   d.level = q.level + 1'b1;
            2'b01:   d.level = q.level - 1'b1;
            default: d.level = q.level;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[q.wp] <= wr_data;
        end
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !full);

    p_level_bound_r3: assert property (@(posedge clk) disable iff (rst)
        q.level <= CW'(DEPTH));

    p_no_underflow_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty && !wr_en) |=> empty);

endmodule

// File: rtl/fb_csum16.sv
module fb_csum16 #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              add_en,
    input  logic [DATA_W-1:0] data,
    output logic [15:0]       sum
);
    localparam int NW = DATA_W / 16;
    localparam int SW = 16 + $clog2(NW + 1);

    logic [15:0] sum_q, sum_d;
    logic [SW-1:0] wide;
    logic [16:0]   fold1;
    logic [16:0]   fold2;

    always_comb begin
        wide = SW'(sum_q);
        for (int k = 0; k < NW; k++) begin
            wide = wide + SW'(data[16*k +: 16]);
        end
        fold1 = 17'(wide[15:0]) + 17'(wide[SW-1:16]);
        fold2 = 17'(fold1[15:0]) + 17'(fold1[16]);
        if (clr) begin
            sum_d = '0;
        end else if (add_en) begin
            sum_d = fold2[15:0];
        end else begin
            sum_d = sum_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
        end else begin
            sum_q <= sum_d;
        end
    end

    assign sum = sum_q;

    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (clr && !add_en) |=> (sum == 16'h0000));

endmodule

// File: rtl/fb_ctrl.sv
module fb_ctrl
    import flow_batch_pkg::*;
#(
    parameter int              MAX_RECS      = 30,
    parameter int              BEATS_PER_REC = 6,
    parameter longint unsigned TIMEOUT_CYC   = 64'd1000
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            beat_acc,
    input  logic                            ack,
    output logic                            batch_ready,
    output logic [$clog2(MAX_RECS+1)-1:0]   rec_count,
    output logic                            ack_taken
);
    localparam int CNT_W = $clog2(MAX_RECS + 1);
    localparam int BW    = (BEATS_PER_REC > 1) ? $clog2(BEATS_PER_REC) : 1;
    localparam int TW    = $clog2(TIMEOUT_CYC + 1);

    typedef struct packed {
        batch_state_e     state;
        logic [BW-1:0]    beat_idx;
        logic [CNT_W-1:0] rec_cnt;
        logic [TW-1:0]    timer;
    } ctrl_t;

    ctrl_t q, d;
    logic  rec_done;
    logic  expired;

    always_comb begin
        d         = q;
        ack_taken = 1'b0;
        rec_done  = beat_acc && (q.beat_idx == BW'(BEATS_PER_REC - 1));
        expired   = (q.timer == TW'(TIMEOUT_CYC));
        case (q.state)
            ST_COLLECT: begin
                if (beat_acc) begin
                    d.beat_idx = rec_done ? '0 : q.beat_idx + 1'b1;
                end
                if (rec_done) begin
                    d.rec_cnt = q.rec_cnt + 1'b1;
                end
                if (q.rec_cnt != '0 && !expired) begin
                    d.timer = q.timer + 1'b1;
                end
                if ((d.rec_cnt == CNT_W'(MAX_RECS)) ||
                    (expired && d.rec_cnt != '0 && d.beat_idx == '0)) begin
                    d.state = ST_READY;
                    d.timer = '0;
                end
            end
            ST_READY: begin
                if (ack) begin
                    d.state   = ST_COLLECT;
                    d.rec_cnt = '0;
                    d.timer   = '0;
                    ack_taken = 1'b1;
                end
            end
            default: d.state = ST_COLLECT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign batch_ready = (q.state == ST_READY);
    assign rec_count   = q.rec_cnt;

    p_count_bound_r4: assert property (@(posedge clk) disable iff (rst)
        q.rec_cnt <= CNT_W'(MAX_RECS));

    p_close_on_max_r4: assert property (@(posedge clk) disable iff (rst)
        (q.state == ST_COLLECT && rec_done && q.rec_cnt == CNT_W'(MAX_RECS - 1))
        |=> (q.state == ST_READY));

    p_empty_never_closes_r6: assert property (@(posedge clk) disable iff (rst)
        (q.state == ST_COLLECT && q.rec_cnt == '0 && !beat_acc)
        |=> (q.state == ST_COLLECT));

    p_no_beat_in_ready_r7: assert property (@(posedge clk) disable iff (rst)
        (q.state == ST_READY) |-> !beat_acc);

    p_ready_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (q.state == ST_READY && !ack) |=> (q.state == ST_READY && $stable(q.rec_cnt)));

    p_ack_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (q.state == ST_READY && ack) |=> (q.state == ST_COLLECT && q.rec_cnt == '0));

    p_partial_holds_r11: assert property (@(posedge clk) disable iff (rst)
        (q.state == ST_COLLECT && q.beat_idx != '0 && !beat_acc)
        |=> (q.state == ST_COLLECT));

endmodule

// File: rtl/flow_batcher.sv
module flow_batcher #(
    parameter int              DATA_W       = 64,
    parameter int              RECORD_BYTES = 48,
    parameter int              MAX_RECS     = 30,
    parameter int              FIFO_RECS    = 60,
    parameter longint unsigned TIMEOUT_CYC  = 64'd9_375_000_000
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [DATA_W-1:0]             s_tdata,
    input  logic                          s_tvalid,
    output logic                          s_tready,
    output logic                          b_ready,
    output logic [$clog2(MAX_RECS+1)-1:0] b_count,
    output logic [15:0]                   b_csum,
    input  logic                          b_ack,
    input  logic                          f_rd_en,
    output logic [DATA_W-1:0]             f_rd_data,
    output logic                          f_empty
);
    localparam int BYTES_PER_BEAT = DATA_W / 8;
    localparam int BEATS_PER_REC  = RECORD_BYTES / BYTES_PER_BEAT;
    localparam int FIFO_DEPTH     = FIFO_RECS * BEATS_PER_REC;

    logic fifo_full;
    logic beat_acc;
    logic ack_taken;

    assign s_tready = !b_ready && !fifo_full;
    assign beat_acc = s_tvalid && s_tready;

    fb_fifo #(
        .W     (DATA_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (beat_acc),
        .wr_data (s_tdata),
        .rd_en   (f_rd_en),
        .rd_data (f_rd_data),
        .full    (fifo_full),
        .empty   (f_empty)
    );

    fb_csum16 #(
        .DATA_W (DATA_W)
    ) u_csum (
        .clk    (clk),
        .rst    (rst),
        .clr    (ack_taken),
        .add_en (beat_acc),
        .data   (s_tdata),
        .sum    (b_csum)
    );

    fb_ctrl #(
        .MAX_RECS      (MAX_RECS),
        .BEATS_PER_REC (BEATS_PER_REC),
        .TIMEOUT_CYC   (TIMEOUT_CYC)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .beat_acc    (beat_acc),
        .ack         (b_ack),
        .batch_ready (b_ready),
        .rec_count   (b_count),
        .ack_taken   (ack_taken)
    );

    p_csum_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        (b_ready && !b_ack) |=> $stable(b_csum));

    p_full_blocks_r3: assert property (@(posedge clk) disable iff (rst)
        (!f_empty && !f_rd_en && !s_tready) |=> !f_empty);

endmodule

// File: tb/flow_batcher_tb.sv
module flow_batcher_tb;
    localparam int DW   = 64;
    localparam int TO   = 300;
    localparam int MAXR = 30;
    localparam int BPR  = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] s_tdata = '0;
    logic          s_tvalid = 1'b0;
    logic          s_tready;
    logic          b_ready;
    logic [4:0]    b_count;
    logic [15:0]   b_csum;
    logic          b_ack = 1'b0;
    logic          f_rd_en = 1'b0;
    logic [DW-1:0] f_rd_data;
    logic          f_empty;

    int checks = 0;
    int fails  = 0;
    int rec_seq = 0;
    logic [15:0]   model_csum = '0;
    logic [DW-1:0] exp_q [$];

    always #5 clk = ~clk;

    flow_batcher #(
        .DATA_W(DW), .RECORD_BYTES(48), .MAX_RECS(MAXR),
        .FIFO_RECS(60), .TIMEOUT_CYC(64'(TO))
    ) u_dut (
        .clk(clk), .rst(rst), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
        .s_tready(s_tready), .b_ready(b_ready), .b_count(b_count),
        .b_csum(b_csum), .b_ack(b_ack), .f_rd_en(f_rd_en),
        .f_rd_data(f_rd_data), .f_empty(f_empty)
    );

    function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [DW-1:0] v);
        int unsigned s = 32'(a);
        for (int k = 0; k < DW / 16; k++) s += 32'(v[16*k +: 16]);
        while ((s >> 16) != 0) s = (s & 32'hFFFF) + (s >> 16);
        return s[15:0];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic send_beat(input logic [DW-1:0] v);
        @(negedge clk);
        s_tvalid = 1'b1;
        s_tdata  = v;
        while (!s_tready) @(negedge clk);
        @(posedge clk);
        #1;
        s_tvalid = 1'b0;
        exp_q.push_back(v);
        model_csum = oc_add(model_csum, v);
    endtask

    task automatic send_record();
        for (int b = 0; b < BPR; b++)
            send_beat({16'hA5A5 ^ 16'(rec_seq), 16'(b), 32'(rec_seq * 32'h9E3779B1 + b)});
        rec_seq++;
    endtask

    task automatic ack_batch();
        @(negedge clk);
        b_ack = 1'b1;
        @(posedge clk);
        #1;
        b_ack = 1'b0;
        model_csum = '0;
    endtask

    task automatic read_beat(input string req);
        logic [DW-1:0] e;
        @(negedge clk);
        e = exp_q.pop_front();
        check(!f_empty && f_rd_data == e, req, "fifo data order", f_rd_data, e);
        f_rd_en = 1'b1;
        @(posedge clk);
        #1;
        f_rd_en = 1'b0;
    endtask

    task automatic check_batch(input string req, input int n);
        @(negedge clk);
        check(b_ready == 1'b1, req, "batch ready", 64'(b_ready), 64'd1);
        check(b_count == 5'(n), req, "batch count", 64'(b_count), 64'(n));
        check(b_csum == model_csum, "R9", "batch checksum", 64'(b_csum), 64'(model_csum));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(s_tready == 1'b1, "R1", "tready after reset", 64'(s_tready), 64'd1);
        check(b_ready == 1'b0, "R1", "ready after reset", 64'(b_ready), 64'd0);
        check(f_empty == 1'b1, "R1", "empty after reset", 64'(f_empty), 64'd1);
        check(b_count == 5'd0, "R1", "count after reset", 64'(b_count), 64'd0);
        check(b_csum == 16'h0, "R1", "csum after reset", 64'(b_csum), 64'd0);
    endtask

    task automatic t_idle_no_close();
        repeat (3 * TO) @(posedge clk);
        @(negedge clk);
        check(b_ready == 1'b0, "R6", "empty batch closed", 64'(b_ready), 64'd0);
    endtask

    task automatic t_count_close();
        for (int r = 0; r < MAXR - 1; r++) send_record();
        @(negedge clk);
        check(b_ready == 1'b0, "R4", "closed before max", 64'(b_ready), 64'd0);
        check(b_count == 5'(MAXR - 1), "R2", "count of whole records", 64'(b_count), 64'(MAXR - 1));
        send_record();
        check_batch("R4", MAXR);
        @(negedge clk);
        s_tvalid = 1'b1;
        s_tdata  = 64'hDEAD_BEEF_0BAD_F00D;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(s_tready == 1'b0, "R7", "tready while ready", 64'(s_tready), 64'd0);
        end
        s_tvalid = 1'b0;
        check_batch("R7", MAXR);
        ack_batch();
        @(negedge clk);
        check(b_ready == 1'b0, "R8", "ready after ack", 64'(b_ready), 64'd0);
        check(b_count == 5'd0, "R8", "count after ack", 64'(b_count), 64'd0);
        check(b_csum == 16'h0, "R8", "csum after ack", 64'(b_csum), 64'd0);
        check(s_tready == 1'b1, "R8", "tready after ack", 64'(s_tready), 64'd1);
    endtask

    task automatic t_timeout();
        send_record();
        repeat (TO) @(posedge clk);
        @(negedge clk);
        check(b_ready == 1'b0, "R5", "ready before timeout", 64'(b_ready), 64'd0);
        @(posedge clk);
        check_batch("R5", 1);
        ack_batch();
    endtask

    task automatic t_partial();
        send_record();
        for (int b = 0; b < 3; b++)
            send_beat({16'hA5A5 ^ 16'(rec_seq), 16'(b), 32'(rec_seq * 32'h9E3779B1 + b)});
        repeat (TO + 20) @(posedge clk);
        @(negedge clk);
        check(b_ready == 1'b0, "R11", "closed mid-record", 64'(b_ready), 64'd0);
        for (int b = 3; b < BPR; b++)
            send_beat({16'hA5A5 ^ 16'(rec_seq), 16'(b), 32'(rec_seq * 32'h9E3779B1 + b)});
        rec_seq++;
        check_batch("R11", 2);
        ack_batch();
    endtask

    task automatic t_ack_ignored();
        @(negedge clk);
        b_ack = 1'b1;
        @(negedge clk);
        b_ack = 1'b0;
        send_record();
        @(negedge clk);
        b_ack = 1'b1;
        @(negedge clk);
        b_ack = 1'b0;
        check(b_count == 5'd1, "R8", "count after stray ack", 64'(b_count), 64'd1);
        repeat (TO + 5) @(posedge clk);
        check_batch("R8", 1);
        ack_batch();
    endtask

    task automatic t_drain_and_empty_read();
        while (exp_q.size() > 0) read_beat("R10");
        @(negedge clk);
        check(f_empty == 1'b1, "R10", "empty after drain", 64'(f_empty), 64'd1);
        f_rd_en = 1'b1;
        repeat (3) @(negedge clk);
        f_rd_en = 1'b0;
        check(f_empty == 1'b1, "R10", "empty after read on empty", 64'(f_empty), 64'd1);
        send_record();
        for (int b = 0; b < BPR; b++) read_beat("R10");
        repeat (TO + 5) @(posedge clk);
        check_batch("R5", 1);
        ack_batch();
    endtask

    task automatic t_full();
        for (int r = 0; r < MAXR; r++) send_record();
        check_batch("R4", MAXR);
        ack_batch();
        for (int r = 0; r < MAXR; r++) send_record();
        check_batch("R12", MAXR);
        ack_batch();
        @(negedge clk);
        check(s_tready == 1'b0, "R3", "tready when full", 64'(s_tready), 64'd0);
        check(b_ready == 1'b0, "R3", "ready when full", 64'(b_ready), 64'd0);
        read_beat("R3");
        @(negedge clk);
        check(s_tready == 1'b1, "R3", "tready after one read", 64'(s_tready), 64'd1);
        while (exp_q.size() > 0) read_beat("R12");
        @(negedge clk);
        check(f_empty == 1'b1, "R12", "empty after full drain", 64'(f_empty), 64'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        t_reset();
        t_idle_no_close();
        t_count_close();
        t_timeout();
        t_partial();
        t_ack_ignored();
        t_drain_and_empty_read();
        t_full();
        finish_up();
    end

endmodule